// File: doc/BRIEF.md
# Ping-Pong Round-Key Store

This block holds expanded cipher round keys between a key-schedule generator and a block-cipher datapath. It contains two storage segments. At any moment one segment is the working bank, which the cipher side reads one complete 128-bit round key at a time. The other is the generating bank, which the key generator fills one 32-bit word at a time. Because each side owns its own segment, a new schedule can be built while blocks are still being ciphered under the previous key. A stored schedule stays readable for any number of message blocks until it is replaced.

The generator writes words into the generating bank by word address and then pulses `gen_done`. That pulse marks the bank complete and raises a pending swap. The roles exchange only when the cipher side reports that it is idle between blocks. The exchange is signalled by a one-cycle `swap_ack`, and `work_bank` shows the new working segment. Each segment has a valid flag, so the cipher side can never read a segment that has never been completely written. Reads have one cycle of latency.

Top module: `rk_pingpong_store`

## Requirements
- R1: After reset, `work_bank` is 0, `swap_pending` is 0, `swap_ack` is 0 and `rd_valid` is 0.
- R2: Writes always land in the generating bank (the one not shown on `work_bank`), and reads always come from the working bank. Writes never change what the cipher side reads before the next swap.
- R3: A read request with `rd_en` high in cycle t produces `rd_valid` and `rd_data` in cycle t+1. In a cycle that follows one without `rd_en`, `rd_valid` is 0.
- R4: Round key r occupies word addresses 4r to 4r+3. Word 4r appears on `rd_data[127:96]`, 4r+1 on `[95:64]`, 4r+2 on `[63:32]` and 4r+3 on `[31:0]`.
- R5: A read from a working bank that has never been marked complete returns `rd_valid` = 0 and `rd_data` = 0.
- R6: A `gen_done` pulse sets `swap_pending` in the next cycle. At the first clock edge where `swap_pending` and `cipher_idle` are both high, `work_bank` toggles, `swap_pending` clears and `swap_ack` is high for the following cycle.
- R7: While `cipher_idle` is low, a pending swap is held: `work_bank` does not change and `swap_pending` stays high.
- R8: A completed schedule returns identical round keys on repeated reads for as long as it remains the working bank.
- R9: A read with `rd_round` of 15 or more returns `rd_valid` = 0.
- R10: A write with `gen_done` low cancels a pending swap and clears the generating bank's valid flag. No swap follows until the next `gen_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one key word into the generating bank |
| wr_addr | input | 6 | Word address 0..59 within the bank |
| wr_data | input | 32 | Key word to store |
| gen_done | input | 1 | Pulse: generating bank now holds a complete schedule |
| cipher_idle | input | 1 | Cipher side is between blocks; a swap may occur |
| rd_en | input | 1 | Read one round key from the working bank |
| rd_round | input | 4 | Round key index 0..14 |
| rd_valid | output | 1 | Read data valid (one cycle after `rd_en`) |
| rd_data | output | 128 | Round key, lowest-addressed word in the top bits |
| swap_pending | output | 1 | Completed bank waiting for an idle cipher side |
| swap_ack | output | 1 | One-cycle pulse after the roles exchange |
| work_bank | output | 1 | Index of the segment currently read by the cipher side |

## Verification
The embedded properties assume that `wr_en` is never high in the same cycle as a swap. Otherwise a word aimed at the old generating bank would land in the new working bank. They also assume that `gen_done` and `wr_en` are not raised together. The bench enforces both assumptions by keeping `cipher_idle` low during every write burst. It raises `cipher_idle` only for the short window it uses to perform a swap, after the writes and the `gen_done` pulse have finished. The swap-gating properties also assume that `cipher_idle` changes only between clock edges, which holds because all inputs are driven on the falling edge.

// File: rtl/rk_store_pkg.sv
// Package: shared constants and types for the ping-pong round-key store.
// Assumes four key words per round key; everything else is parameterised at the top.
package rk_store_pkg;
    localparam int WORDS_PER_KEY = 4;

    typedef enum logic {
        SEG_A = 1'b0,
        SEG_B = 1'b1
    } seg_t;
endpackage

// File: rtl/rk_seg_mem.sv
// Module: one storage segment, written by word and read by whole round key.
// Assumes the caller gates the write enable to the generating segment only.
// Read data is registered, which gives the one-cycle read latency.
module rk_seg_mem
    import rk_store_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int MAX_KEYS = 15,
    parameter int ADDR_W   = 6,
    parameter int RND_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 waddr,
    input  logic [WORD_W-1:0]                 wdata,
    input  logic                              re,
    input  logic [RND_W-1:0]                  rround,
    output logic [WORDS_PER_KEY*WORD_W-1:0]   rkey
);
    localparam int SEG_WORDS = MAX_KEYS * WORDS_PER_KEY;
    localparam logic [ADDR_W:0] SEG_WORDS_L = (ADDR_W+1)'(SEG_WORDS);
    localparam logic [RND_W:0]  KEYS_L      = (RND_W+1)'(MAX_KEYS);

    logic [WORD_W-1:0] mem [MAX_KEYS][WORDS_PER_KEY];

    // Store one word when enabled and in range.
    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < SEG_WORDS_L)) begin
            mem[waddr[ADDR_W-1:2]][waddr[1:0]] <= wdata;
        end
    end

    // Capture one round key with the lowest-addressed word in the top bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rkey <= '0;
        end else if (re && ({1'b0, rround} < KEYS_L)) begin
            for (int j = 0; j < WORDS_PER_KEY; j++) begin
                rkey[(WORDS_PER_KEY-1-j)*WORD_W +: WORD_W] <= mem[rround][j];
            end
        end
    end
endmodule

// File: rtl/rk_swap_ctrl.sv
// Module: role control for the two segments.
// Tracks which segment is working, the per-segment valid flags and the pending swap.
// Assumes wr_en and gen_done are never high together, and that no write occurs
// in the cycle a swap is taken.
module rk_swap_ctrl
    import rk_store_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       gen_done,
    input  logic       cipher_idle,
    output logic       work_sel,
    output logic [1:0] seg_valid,
    output logic       swap_pending,
    output logic       swap_ack
);
    seg_t work_q;
    logic fire;

    assign fire     = swap_pending && cipher_idle;
    assign work_sel = work_q;

    // Exchange roles on a granted swap and pulse the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q   <= SEG_A;
            swap_ack <= 1'b0;
        end else begin
            swap_ack <= fire;
            if (fire) work_q <= (work_q == SEG_A) ? SEG_B : SEG_A;
        end
    end

    // Pending swap: the last applicable event wins (grant, then write, then done).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_pending <= 1'b0;
        end else begin
            if (fire)     swap_pending <= 1'b0;
            if (wr_en)    swap_pending <= 1'b0;
            if (gen_done) swap_pending <= 1'b1;
        end
    end

    // Valid flag of the generating segment: a write clears it, completion sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_valid <= 2'b00;
        end else if (gen_done) begin
            seg_valid[~work_q] <= 1'b1;
        end else if (wr_en) begin
            seg_valid[~work_q] <= 1'b0;
        end
    end

    // R6: the working segment changes only after a pending swap met an idle cipher side.
    assert_swap_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (work_sel != $past(work_sel)) |-> $past(swap_pending && cipher_idle));

    // R6: an acknowledge is only seen after a pending swap.
    assert_ack_after_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> $past(swap_pending));

    // R7: a busy cipher side holds the pending swap and the current roles.
    assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pending && !cipher_idle && !wr_en) |=> (swap_pending && $stable(work_sel)));

    // R10: a plain write leaves no swap pending.
    assert_write_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !gen_done) |=> !swap_pending);
endmodule

// File: rtl/rk_pingpong_store.sv
// Module: top of the ping-pong round-key store.
// The key generator writes 32-bit words into the generating segment, and the cipher
// side reads 128-bit round keys from the working segment with one cycle of latency.
// Assumes the input rules listed in rk_swap_ctrl.
module rk_pingpong_store
    import rk_store_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int MAX_KEYS = 15,
    localparam int KEY_W   = WORDS_PER_KEY * WORD_W,
    localparam int ADDR_W  = $clog2(MAX_KEYS * WORDS_PER_KEY),
    localparam int RND_W   = $clog2(MAX_KEYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              gen_done,
    input  logic              cipher_idle,
    input  logic              rd_en,
    input  logic [RND_W-1:0]  rd_round,
    output logic              rd_valid,
    output logic [KEY_W-1:0]  rd_data,
    output logic              swap_pending,
    output logic              swap_ack,
    output logic              work_bank
);
    localparam logic [RND_W:0] KEYS_L = (RND_W+1)'(MAX_KEYS);

    logic             work_sel;
    logic [1:0]       seg_valid;
    logic [KEY_W-1:0] seg_key [2];
    logic             sel_q;

    rk_swap_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .gen_done     (gen_done),
        .cipher_idle  (cipher_idle),
        .work_sel     (work_sel),
        .seg_valid    (seg_valid),
        .swap_pending (swap_pending),
        .swap_ack     (swap_ack)
    );

    // Two identical segments; only the generating one sees write enables.
    for (genvar b = 0; b < 2; b++) begin : g_seg
        rk_seg_mem #(
            .WORD_W   (WORD_W),
            .MAX_KEYS (MAX_KEYS),
            .ADDR_W   (ADDR_W),
            .RND_W    (RND_W)
        ) u_seg (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && (work_sel != 1'(b))),
            .waddr  (wr_addr),
            .wdata  (wr_data),
            .re     (rd_en),
            .rround (rd_round),
            .rkey   (seg_key[b])
        );
    end

    // Register the read qualifier and the segment it addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            rd_valid <= rd_en && ({1'b0, rd_round} < KEYS_L) && seg_valid[work_sel];
            sel_q    <= work_sel;
        end
    end

    // Present the addressed key, or zero when the read was refused.
    assign rd_data   = rd_valid ? seg_key[sel_q] : '0;
    assign work_bank = work_sel;

    // R3: read data is valid only one cycle after a request.
    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R5: valid data only comes from a segment that was marked complete.
    assert_read_complete_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(seg_valid[work_sel]));

    // R9: out-of-range round indices are never answered.
    assert_round_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past({1'b0, rd_round} < KEYS_L));
endmodule

// File: tb/rk_pingpong_store_bench.sv
module rk_pingpong_store_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         gen_done = 1'b0;
    logic         cipher_idle = 1'b0;
    logic         rd_en = 1'b0;
    logic [3:0]   rd_round = '0;
    logic         rd_valid;
    logic [127:0] rd_data;
    logic         swap_pending;
    logic         swap_ack;
    logic         work_bank;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rk_pingpong_store u_rk_pingpong_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gen_done(gen_done), .cipher_idle(cipher_idle), .rd_en(rd_en), .rd_round(rd_round),
        .rd_valid(rd_valid), .rd_data(rd_data), .swap_pending(swap_pending),
        .swap_ack(swap_ack), .work_bank(work_bank)
    );

    function automatic logic [31:0] word_of(input logic [7:0] tag, input int a);
        return {tag, 8'h5A, 8'(a), ~8'(a)};
    endfunction

    function automatic logic [127:0] key_of(input logic [7:0] tag, input int r);
        return {word_of(tag, 4*r), word_of(tag, 4*r+1), word_of(tag, 4*r+2), word_of(tag, 4*r+3)};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_all(input logic [7:0] tag);
        for (int a = 0; a < 60; a++) begin
            @(negedge clk); wr_en = 1'b1; wr_addr = 6'(a); wr_data = word_of(tag, a);
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); gen_done = 1'b1;
        @(negedge clk); gen_done = 1'b0;
    endtask

    task automatic read_key(input int r, output logic v, output logic [127:0] d);
        @(negedge clk); rd_en = 1'b1; rd_round = 4'(r);
        @(negedge clk); rd_en = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic do_swap(input logic exp_bank);
        @(negedge clk); cipher_idle = 1'b1;
        @(negedge clk); cipher_idle = 1'b0;
        check("R6 swap_ack", 128'(swap_ack), 128'(1));
        check("R6 work_bank", 128'(work_bank), 128'(exp_bank));
        check("R6 pending cleared", 128'(swap_pending), 128'(0));
        @(negedge clk);
        check("R6 ack one cycle", 128'(swap_ack), 128'(0));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 work_bank", 128'(work_bank), 128'(0));
        check("R1 swap_pending", 128'(swap_pending), 128'(0));
        check("R1 swap_ack", 128'(swap_ack), 128'(0));
        check("R1 rd_valid", 128'(rd_valid), 128'(0));
    endtask

    task automatic t_unwritten();
        logic v; logic [127:0] d;
        read_key(0, v, d);
        check("R5 unwritten valid", 128'(v), 128'(0));
        check("R5 unwritten data", d, 128'(0));
    endtask

    task automatic t_first_load();
        logic v; logic [127:0] d;
        write_all(8'hA1);
        pulse_done();
        check("R6 pending set", 128'(swap_pending), 128'(1));
        repeat (4) @(negedge clk);
        check("R7 held pending", 128'(swap_pending), 128'(1));
        check("R7 held bank", 128'(work_bank), 128'(0));
        read_key(2, v, d);
        check("R5 still invalid while pending", 128'(v), 128'(0));
        do_swap(1'b1);
    endtask

    task automatic t_layout();
        logic v; logic [127:0] d;
        int rounds [3] = '{0, 7, 14};
        foreach (rounds[i]) begin
            read_key(rounds[i], v, d);
            check("R3 valid next cycle", 128'(v), 128'(1));
            check("R4 key layout", d, key_of(8'hA1, rounds[i]));
            @(negedge clk);
            check("R3 no valid without request", 128'(rd_valid), 128'(0));
        end
    endtask

    task automatic t_overlap();
        logic v; logic [127:0] d;
        write_all(8'hB2);
        read_key(5, v, d);
        check("R2 working bank undisturbed", d, key_of(8'hA1, 5));
        for (int k = 0; k < 5; k++) begin
            read_key(3, v, d);
            check("R8 repeated read", d, key_of(8'hA1, 3));
        end
        pulse_done();
        do_swap(1'b0);
        read_key(9, v, d);
        check("R2 new schedule after swap", d, key_of(8'hB2, 9));
    endtask

    task automatic t_range();
        logic v; logic [127:0] d;
        read_key(15, v, d);
        check("R9 out of range valid", 128'(v), 128'(0));
    endtask

    task automatic t_cancel();
        logic v; logic [127:0] d;
        pulse_done();
        check("R10 pending before write", 128'(swap_pending), 128'(1));
        @(negedge clk); wr_en = 1'b1; wr_addr = 6'd0; wr_data = word_of(8'hC3, 0);
        @(negedge clk); wr_en = 1'b0;
        check("R10 pending cancelled", 128'(swap_pending), 128'(0));
        @(negedge clk); cipher_idle = 1'b1;
        repeat (3) @(negedge clk);
        cipher_idle = 1'b0;
        check("R10 no swap after cancel", 128'(work_bank), 128'(0));
        read_key(1, v, d);
        check("R10 old schedule kept", d, key_of(8'hB2, 1));
        pulse_done();
        do_swap(1'b1);
        read_key(0, v, d);
        check("R10 rewritten word", d, {word_of(8'hC3, 0), word_of(8'hA1, 1),
                                         word_of(8'hA1, 2), word_of(8'hA1, 3)});
    endtask

    initial begin
        t_reset();
        t_unwritten();
        t_first_load();
        t_layout();
        t_overlap();
        t_range();
        t_cancel();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule